// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

A bank of 32 general-purpose pins on a simple word-addressed register bus. Each pin has a direction bit and an output data bit. The synchronized input level of every pin can be read back. A per-pin interrupt detector feeds one combined interrupt line for the whole bank.

Every configuration register has four word addresses. One address reads and writes the register directly. The other three set, clear or toggle only the bits written as one, so a driver can change one pin without a read-modify-write. Each pin can detect a level or an edge, with selectable polarity and an optional both-edge mode. Edge events latch until software writes a one to that pin's clear bit. Level status follows the synchronized pin and cannot be cleared by software.

Register groups are 16 bytes apart and each holds one bit per pin. Bits [3:2] of the address select the alias: 0 direct, 1 set, 2 clear, 3 toggle. The groups and their offsets:

- 0x00: direction
- 0x10: output data
- 0x20: interrupt enable
- 0x30: interrupt mask
- 0x40: detect type
- 0x50: polarity
- 0x60: both-edge
- 0x70: edge clear (write only)
- 0x80: input levels (read only)
- 0x90: raw status (read only)
- 0xA0: masked status (read only)

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, all pins are inputs (pin_oe 0) and pin_out is 0. Interrupt enable reads 0, the mask at 0x30 reads all ones, both status registers read 0, and irq_out is 0.
- R2: A write to a group's +0x0 address replaces the register. A write to +0x4 sets the bits written as 1, +0x8 clears them, and +0xC inverts them. For direction (1 = output) and output data, pin_oe and pin_out follow the register from the clock edge of the write. A read of any of the four aliases returns the register value.
- R3: A read of 0x80 returns the pin levels through a two-flop synchronizer. If a pin changes before rising edge k, a read sampled at edge k+1 returns the old level and a read sampled at edge k+2 returns the new level.
- R4: When detect type is 0 (level), the raw status bit is 1 while the synchronized pin equals the polarity bit (1 = high, 0 = low). The bit drops when the pin leaves that level, and writing 1 to the edge clear group (0x70) does not drop it.
- R5: When detect type is 1 (edge) and both-edge is 0, only the edge that polarity selects is latched (1 = rising, 0 = falling). The latched status stays set after the pin returns to its earlier level.
- R6: When detect type is 1 and both-edge is 1, rising and falling edges both latch status, whatever the polarity.
- R7: With the enable bit at 0, a pin shows no raw status in either mode. An edge seen while the pin is disabled is not latched and does not appear once the pin is enabled.
- R8: A mask bit of 1 removes the pin from the masked status (0xA0) and from irq_out. The raw status (0x90) still shows the pin.
- R9: Writing 1 to a pin's bit in the edge clear group, at any alias, clears its latched edge status. If a new qualifying edge arrives in the same cycle as the clear, the status stays set.
- R10: irq_out is 1 exactly when at least one bit of the masked status is 1.
- R11: Writes to the read-only groups (0x80, 0x90, 0xA0) change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the read |
| pin_in | input | 32 | Pin input levels, asynchronous to clk |
| pin_out | output | 32 | Output data to the pads |
| pin_oe | output | 32 | Output enable to the pads, 1 = drive |
| irq_out | output | 1 | Combined bank interrupt |

## Verification
Each result has its own latency:

- A register write takes effect on pin_oe and pin_out from the edge that samples it.
- Read data appears after the edge that samples the read.
- A pin change reaches the input register two edges later.
- Level status follows that register without a further delay.
- Edge status latches one edge after the synchronized change.

The bench waits three cycles after each pin change before it reads status or checks irq_out. The synchronizer delay is pinned down with two back-to-back reads, one cycle apart, that expect the old and then the new level. The clear-versus-new-edge race is placed so the clear write is sampled on the same edge that latches the edge. The read scoreboard compares each returned word at the falling edge after the read was sampled.

// File: rtl/gpio_irq_pkg.sv
// Shared constants for the GPIO bank: register group numbers and write aliases.
// Assumes byte addresses with 16-byte groups and the alias selected by address bits [3:2].
package gpio_irq_pkg;

    typedef enum logic [1:0] {
        ALIAS_PLAIN = 2'd0,
        ALIAS_SET   = 2'd1,
        ALIAS_CLR   = 2'd2,
        ALIAS_TOG   = 2'd3
    } alias_e;

    // writable configuration groups, numbered from zero so they can index an array
    localparam int unsigned G_DIR   = 0;
    localparam int unsigned G_DOUT  = 1;
    localparam int unsigned G_EN    = 2;
    localparam int unsigned G_MASK  = 3;
    localparam int unsigned G_TYPE  = 4;
    localparam int unsigned G_POL   = 5;
    localparam int unsigned G_BOTH  = 6;
    localparam int unsigned NUM_CFG = 7;

    // special groups
    localparam int unsigned G_CLR   = 7;
    localparam int unsigned G_DIN   = 8;
    localparam int unsigned G_RAW   = 9;
    localparam int unsigned G_MSK   = 10;

endpackage

// File: rtl/gpio_irq_regs.sv
// Configuration register file with plain, set, clear and toggle write aliases.
// Also produces a one-cycle edge-clear vector when the clear group is written.
// Assumes wr_en is a single-cycle strobe qualified by the bus select.
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [NPINS-1:0]                 wdata,
    output logic [NUM_CFG-1:0][NPINS-1:0]    cfg_q,
    output logic [NPINS-1:0]                 clr_vec
);

    localparam int unsigned GRP_W = ADDR_W - 4;

    logic [GRP_W-1:0] grp;
    alias_e           alias_sel;
    logic             unused_lo;

    // split the byte address into group, alias and the ignored byte lane bits
    always_comb begin
        grp       = addr[ADDR_W-1:4];
        alias_sel = alias_e'(addr[3:2]);
        unused_lo = ^addr[1:0];
    end

    // apply one aliased write to the current register value
    function automatic logic [NPINS-1:0] alias_apply(
        input logic [NPINS-1:0] cur,
        input logic [NPINS-1:0] wd,
        input alias_e           a
    );
        case (a)
            ALIAS_SET: return cur | wd;
            ALIAS_CLR: return cur & ~wd;
            ALIAS_TOG: return cur ^ wd;
            default:   return wd;
        endcase
    endfunction

    genvar g;
    generate
        for (g = 0; g < NUM_CFG; g++) begin : g_cfg
            localparam logic [NPINS-1:0] RST_VAL = (g == G_MASK) ? '1 : '0;

            // hold one configuration group, updated by writes to any of its aliases
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cfg_q[g] <= RST_VAL;
                end else if (wr_en && (grp == GRP_W'(g))) begin
                    cfg_q[g] <= alias_apply(cfg_q[g], wdata, alias_sel);
                end
            end
        end
    endgenerate

    // a write of ones to the clear group, at any alias, pulses the clear vector
    always_comb begin
        clr_vec = (wr_en && (grp == GRP_W'(G_CLR))) ? wdata : '0;
    end

endmodule

// File: rtl/gpio_irq_sync.sv
// Multi-flop synchronizer for asynchronous pin inputs.
// Assumes each bit is an independent level; no multi-bit coherency is implied.
module gpio_irq_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // shift the pin levels through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    always_comb q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_detect.sv
// Interrupt detector for one pin: level or edge, polarity, both-edge, sticky edge latch.
// Assumes din is already synchronized to clk. A new edge beats a same-cycle clear.
module gpio_irq_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic en,
    input  logic edge_mode,
    input  logic pol_high,
    input  logic both,
    input  logic clr,
    output logic raw,
    output logic edge_q
);

    logic prev_q;
    logic rise;
    logic fall;
    logic hit;

    // remember the previous synchronized level for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= din;
    end

    // decide whether this cycle carries a qualifying edge
    always_comb begin
        rise = din & ~prev_q;
        fall = ~din & prev_q;
        if (both) hit = rise | fall;
        else      hit = pol_high ? rise : fall;
        hit = hit & edge_mode & en;
    end

    // latch edges until cleared; a new hit wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) edge_q <= 1'b0;
        else        edge_q <= hit | (edge_q & ~clr);
    end

    // raw status: the latch in edge mode, the live level in level mode
    always_comb begin
        raw = en & (edge_mode ? edge_q : (din == pol_high));
    end

endmodule

// File: rtl/gpio_irq_bank.sv
// GPIO bank top: register bus, pad outputs, input synchronizer, per-pin
// interrupt detectors, status read-back and the combined interrupt.
// Assumes one bus access per cycle; read data is registered and valid one cycle later.
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS       = 32,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq_out
);

    localparam int unsigned GRP_W = ADDR_W - 4;

    logic [NUM_CFG-1:0][NPINS-1:0] cfg_q;
    logic [NPINS-1:0] clr_vec;
    logic [NPINS-1:0] din_sync;
    logic [NPINS-1:0] raw_stat;
    logic [NPINS-1:0] edge_stat;
    logic [NPINS-1:0] masked_stat;
    logic [NPINS-1:0] cfg_en;
    logic [NPINS-1:0] cfg_mask;
    logic [NPINS-1:0] rd_mux;
    logic [GRP_W-1:0] rd_grp;

    gpio_irq_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_sel & bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .cfg_q   (cfg_q),
        .clr_vec (clr_vec)
    );

    gpio_irq_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (din_sync)
    );

    genvar p;
    generate
        for (p = 0; p < NPINS; p++) begin : g_pin
            gpio_irq_detect det_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .din       (din_sync[p]),
                .en        (cfg_q[G_EN][p]),
                .edge_mode (cfg_q[G_TYPE][p]),
                .pol_high  (cfg_q[G_POL][p]),
                .both      (cfg_q[G_BOTH][p]),
                .clr       (clr_vec[p]),
                .raw       (raw_stat[p]),
                .edge_q    (edge_stat[p])
            );
        end
    endgenerate

    // drive pads and combine interrupt status
    always_comb begin
        pin_oe      = cfg_q[G_DIR];
        pin_out     = cfg_q[G_DOUT];
        cfg_en      = cfg_q[G_EN];
        cfg_mask    = cfg_q[G_MASK];
        masked_stat = raw_stat & ~cfg_mask;
        irq_out     = |masked_stat;
    end

    // select the read word by group; all four aliases read the same value
    always_comb begin
        rd_grp = bus_addr[ADDR_W-1:4];
        rd_mux = '0;
        if (rd_grp < GRP_W'(NUM_CFG)) begin
            rd_mux = cfg_q[rd_grp[$clog2(NUM_CFG)-1:0]];
        end else if (rd_grp == GRP_W'(G_DIN)) begin
            rd_mux = din_sync;
        end else if (rd_grp == GRP_W'(G_RAW)) begin
            rd_mux = raw_stat;
        end else if (rd_grp == GRP_W'(G_MSK)) begin
            rd_mux = masked_stat;
        end
    end

    // register read data on a read access
    always_ff @(posedge clk) begin
        if (!rst_n)                  bus_rdata <= '0;
        else if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
    end

endmodule

// File: rtl/gpio_irq_bank_chk.sv
// Assertion checker for the GPIO bank, bound to every gpio_irq_bank instance.
// Assumes visibility of the enable, mask, edge latch and clear vector of the top.
module gpio_irq_bank_chk #(
    parameter int unsigned NPINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [NPINS-1:0] pin_oe,
    input logic             irq_out,
    input logic [NPINS-1:0] cfg_en,
    input logic [NPINS-1:0] cfg_mask,
    input logic [NPINS-1:0] edge_stat,
    input logic [NPINS-1:0] clr_vec
);

    // R2: pad direction moves only on a bus write
    a_r2_oe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> $stable(pin_oe));

    // R5: a latched edge survives every cycle without a clear
    a_r5_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(edge_stat) & ~$past(clr_vec)) & ~edge_stat) == '0));

    // R7: a newly latched edge needs the pin enabled in the cycle before
    a_r7_latch_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((edge_stat & ~$past(edge_stat) & ~$past(cfg_en)) == '0));

    // R8: with every pin masked the interrupt line stays low
    a_r8_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&cfg_mask) |-> !irq_out);

    // R10: the interrupt needs at least one enabled, unmasked pin
    a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((cfg_en & ~cfg_mask) != '0));

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .pin_oe    (pin_oe),
    .irq_out   (irq_out),
    .cfg_en    (cfg_en),
    .cfg_mask  (cfg_mask),
    .edge_stat (edge_stat),
    .clr_vec   (clr_vec)
);

// File: tb/gpio_irq_bank_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected words, a monitor compares returned data.
module gpio_irq_bank_tb_top;

    localparam logic [7:0] A_DIR = 8'h00, A_DOUT = 8'h10, A_EN  = 8'h20, A_MASK = 8'h30;
    localparam logic [7:0] A_TYPE = 8'h40, A_POL = 8'h50, A_BOTH = 8'h60, A_CLR = 8'h70;
    localparam logic [7:0] A_DIN = 8'h80, A_RAW = 8'h90, A_MSK = 8'hA0;
    localparam logic [7:0] O_SET = 8'h4, O_CLR = 8'h8, O_TOG = 8'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq_out;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_due = 1'b0;

    always #4 clk = ~clk;

    gpio_irq_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    // monitor: note reads sampled at this edge, compare at the next falling edge
    always @(posedge clk) rd_due <= bus_sel && !bus_wr;

    always @(negedge clk) begin
        if (rd_due) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            if (bus_rdata !== e) begin
                n_bad++;
                $display("FAIL %s act=%h exp=%h", t, bus_rdata, e);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] e);
        n_vec++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", t, act, e);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk("R1 pin_oe", pin_oe, 32'h0);
        chk("R1 pin_out", pin_out, 32'h0);
        chk("R1 irq_out", {31'h0, irq_out}, 32'h0);
        rd(A_EN, 32'h0, "R1 enable");
        rd(A_MASK, 32'hFFFF_FFFF, "R1 mask");
        rd(A_RAW, 32'h0, "R1 raw");
        rd(A_MSK, 32'h0, "R1 masked");

        // R2 aliases on direction and output data
        wr(A_DIR, 32'h0000_00F0);
        wr(A_DIR + O_SET, 32'h0000_000F);
        wr(A_DIR + O_CLR, 32'h0000_0030);
        wr(A_DIR + O_TOG, 32'h0000_0101);
        chk("R2 pin_oe", pin_oe, 32'h0000_01CE);
        rd(A_DIR + O_SET, 32'h0000_01CE, "R2 dir via set alias");
        rd(A_DIR + O_TOG, 32'h0000_01CE, "R2 dir via toggle alias");
        wr(A_DOUT + O_SET, 32'h0000_00A5);
        wr(A_DOUT + O_TOG, 32'h0000_00FF);
        chk("R2 pin_out", pin_out, 32'h0000_005A);
        rd(A_DOUT + O_CLR, 32'h0000_005A, "R2 dout via clear alias");

        // R11 writes to read-only groups are ignored
        wr(A_DIN, 32'hFFFF_FFFF);
        wr(A_RAW + O_SET, 32'hFFFF_FFFF);
        wr(A_MSK, 32'hFFFF_FFFF);
        rd(A_DIN, 32'h0, "R11 din unchanged");
        rd(A_RAW, 32'h0, "R11 raw unchanged");
        chk("R11 pin_oe", pin_oe, 32'h0000_01CE);
        chk("R11 pin_out", pin_out, 32'h0000_005A);

        // R3 synchronizer: change before edge k, old at k+1, new at k+2
        pin_in = 32'h1234_5678;
        idle(3);
        rd(A_DIN, 32'h1234_5678, "R3 din settled");
        pin_in = 32'h8000_0001;
        idle(1);
        rd(A_DIN, 32'h1234_5678, "R3 din old at k+1");
        rd(A_DIN, 32'h8000_0001, "R3 din new at k+2");
        pin_in = 32'h0;
        idle(3);

        // R4 level mode, pin 1, active high
        wr(A_POL + O_SET, 32'h2);
        wr(A_EN + O_SET, 32'h2);
        wr(A_MASK + O_CLR, 32'h2);
        rd(A_RAW, 32'h0, "R4 level inactive");
        pin_in[1] = 1'b1;
        idle(3);
        rd(A_RAW, 32'h2, "R4 level high active");
        chk("R10 irq on level", {31'h0, irq_out}, 32'h1);
        wr(A_CLR, 32'h2);
        rd(A_RAW, 32'h2, "R4 clear does not drop level");
        pin_in[1] = 1'b0;
        idle(3);
        rd(A_RAW, 32'h0, "R4 level drops with pin");
        chk("R10 irq off", {31'h0, irq_out}, 32'h0);
        wr(A_POL + O_CLR, 32'h2);
        rd(A_RAW, 32'h2, "R4 low level active");
        wr(A_EN + O_CLR, 32'h2);
        rd(A_RAW, 32'h0, "R7 level disabled");

        // R5 single edge, pin 2, rising then falling
        wr(A_TYPE + O_SET, 32'h4);
        wr(A_POL + O_SET, 32'h4);
        wr(A_EN + O_SET, 32'h4);
        wr(A_MASK + O_CLR, 32'h4);
        pin_in[2] = 1'b1;
        idle(3);
        rd(A_RAW, 32'h4, "R5 rising latched");
        chk("R10 irq on edge", {31'h0, irq_out}, 32'h1);
        pin_in[2] = 1'b0;
        idle(3);
        rd(A_RAW, 32'h4, "R5 sticky after return");
        wr(A_CLR + O_CLR, 32'h4);
        rd(A_RAW, 32'h0, "R9 clear via alias");
        wr(A_POL + O_CLR, 32'h4);
        pin_in[2] = 1'b1;
        idle(3);
        rd(A_RAW, 32'h0, "R5 rising ignored for falling polarity");
        pin_in[2] = 1'b0;
        idle(3);
        rd(A_RAW, 32'h4, "R5 falling latched");
        wr(A_CLR, 32'h4);

        // R6 both edges, pin 3, polarity 0
        wr(A_TYPE + O_SET, 32'h8);
        wr(A_BOTH + O_SET, 32'h8);
        wr(A_EN + O_SET, 32'h8);
        wr(A_MASK + O_CLR, 32'h8);
        pin_in[3] = 1'b1;
        idle(3);
        rd(A_RAW, 32'h8, "R6 rising in both mode");
        wr(A_CLR, 32'h8);
        rd(A_RAW, 32'h0, "R9 cleared");
        pin_in[3] = 1'b0;
        idle(3);
        rd(A_RAW, 32'h8, "R6 falling in both mode");

        // R9 new edge in the same cycle as a clear keeps status set
        pin_in[3] = 1'b1;
        idle(2);
        wr(A_CLR, 32'h8);
        rd(A_RAW, 32'h8, "R9 new edge beats clear");
        wr(A_CLR, 32'h8);
        rd(A_RAW, 32'h0, "R9 later clear");

        // R8 mask, pin 4 rising edge, still masked
        wr(A_TYPE + O_SET, 32'h10);
        wr(A_POL + O_SET, 32'h10);
        wr(A_EN + O_SET, 32'h10);
        pin_in[4] = 1'b1;
        idle(3);
        rd(A_RAW, 32'h10, "R8 raw shows masked pin");
        rd(A_MSK, 32'h0, "R8 masked hides pin");
        chk("R8 irq masked", {31'h0, irq_out}, 32'h0);
        wr(A_MASK + O_CLR, 32'h10);
        rd(A_MSK, 32'h10, "R8 unmasked shows pin");
        chk("R10 irq unmasked", {31'h0, irq_out}, 32'h1);
        wr(A_MASK + O_SET, 32'h10);
        chk("R10 irq remasked", {31'h0, irq_out}, 32'h0);
        wr(A_CLR, 32'h10);
        rd(A_RAW, 32'h0, "R9 pin4 cleared");

        // R7 edge while disabled, pin 5
        wr(A_TYPE + O_SET, 32'h20);
        wr(A_POL + O_SET, 32'h20);
        wr(A_MASK + O_CLR, 32'h20);
        pin_in[5] = 1'b1;
        idle(3);
        rd(A_RAW, 32'h0, "R7 disabled edge ignored");
        wr(A_EN + O_SET, 32'h20);
        rd(A_RAW, 32'h0, "R7 no late latch after enable");
        chk("R7 irq low", {31'h0, irq_out}, 32'h0);

        idle(3);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule